// File: doc/BRIEF.md
# Floating-point control and status register pair

This block keeps the two architectural registers that sit beside a 32-bit floating-point datapath. One is a control word: its low two bits give the rounding direction the arithmetic must use, and the five bits above them enable individual exceptions. The other is a status word holding five sticky exception flags. Software reaches both through a simple user-register port: a one-cycle write strobe with a select bit and 32 data bits, plus a combinational read port with its own select bit.

The datapath raises one-cycle flag pulses as operations complete. The block ORs them into the sticky status bits every cycle until software overwrites the status word. Bits that are reserved are dropped on write and read back as zero. Bits 31:12 of either word must be zero. A write that sets any of them still stores its legal bits, and it produces a one-cycle error pulse. A parameter selects a compatibility variant. That variant keeps every control bit except 11:7 and does not flag control writes as errors.

Top module: `fpcsr_top`

## Requirements
- R1: `round_mode` equals control bits 1:0: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R2: With COMPAT=0 a control write keeps only bits 6:0. Bits 6:2 are the enable field, in the same order as the flags. Every other control bit reads as zero.
- R3: With COMPAT=1 a control write keeps every bit except 11:7, which is mask 0xFFFFF07F. A control write never raises `mbz_err` in this variant.
- R4: `mbz_err` is high for exactly the one cycle after a write that sets any of bits 31:12. This applies to status writes in both variants and to control writes with COMPAT=0. The legal bits of that write are still stored.
- R5: The status word holds the flags in bits 11:7: bit 7 inexact, 8 underflow, 9 overflow, 10 divide-by-zero, 11 invalid. Every other status bit reads as zero.
- R6: A status write replaces all five flags with `wr_data[11:7]`.
- R7: Each `flag_pulse[i]` (bit 0 inexact up to bit 4 invalid) is ORed into flag i on every clock. A set flag stays set until a status write or reset.
- R8: When a status write and flag pulses fall in the same cycle, the written value is stored and those pulses are lost.
- R9: Reset clears both registers and `mbz_err`, which selects nearest-even rounding.
- R10: `rd_data` shows the control word when `rd_sel`=0 and the status word when `rd_sel`=1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 control, 1 status |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 status |
| rd_data | output | 32 | Read data, combinational |
| flag_pulse | input | 5 | Exception pulses from the datapath |
| round_mode | output | 2 | Rounding direction code to the datapath |
| mbz_err | output | 1 | One-cycle pulse after a write that sets bits 31:12 |

## Verification
The cycle that needs care is the one where a status write meets datapath flag pulses. Both update the sticky flags on the same edge. The bench drives a status write together with pulses on different flag bits. It then reads the status word and expects only the written pattern. A flag raised by a pulse in the cycle after the write must then accumulate on top of that written value.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_FLAG = 5;
  localparam int unsigned FLAG_LSB = 7;   // status flag field base
  localparam int unsigned MBZ_LSB  = 12;  // start of must-be-zero field
  localparam int unsigned CTL_KEEP = 7;   // control bits kept, standard variant

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_TO_ZERO   = 2'd1,
    RND_TO_POS    = 2'd2,
    RND_TO_NEG    = 2'd3
  } rnd_mode_e;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/fpcsr_ctrl_reg.sv
module fpcsr_ctrl_reg #(
  parameter int unsigned DW      = 32,
  parameter int unsigned KEEP_LO = 7,
  parameter int unsigned GAP_HI  = 12,
  parameter bit          COMPAT  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ctrl_q
);
  localparam logic [DW-1:0] STD_MASK = {{(DW-KEEP_LO){1'b0}}, {KEEP_LO{1'b1}}};
  localparam logic [DW-1:0] GAP_MASK =
    {{(DW-GAP_HI){1'b0}}, {(GAP_HI-KEEP_LO){1'b1}}, {KEEP_LO{1'b0}}};

  logic [DW-1:0] keep_mask;
  logic [DW-1:0] ctrl_d;

  generate
    if (COMPAT) begin : g_compat
      assign keep_mask = ~GAP_MASK;
    end else begin : g_std
      assign keep_mask = STD_MASK;
    end
  endgenerate

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_fire) ctrl_d = wr_data & keep_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_fire) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/fpcsr_flag_reg.sv
module fpcsr_flag_reg #(
  parameter int unsigned NF = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [NF-1:0] wr_flags,
  input  logic [NF-1:0] pulse,
  output logic [NF-1:0] flags_q
);
  logic [NF-1:0] flags_d;
  logic          upd_en;

  // A software write wins over datapath pulses in the same cycle.
  always_comb begin
    if (wr_fire) flags_d = wr_flags;
    else         flags_d = flags_q | pulse;
    upd_en = wr_fire | (|pulse);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end
endmodule

// File: rtl/fpcsr_rnd_dec.sv
module fpcsr_rnd_dec
  import fpcsr_pkg::*;
(
  input  logic [1:0] ctrl_lo,
  output rnd_mode_e  mode
);
  always_comb begin
    unique case (ctrl_lo)
      2'd0:    mode = RND_NEAR_EVEN;
      2'd1:    mode = RND_TO_ZERO;
      2'd2:    mode = RND_TO_POS;
      default: mode = RND_TO_NEG;
    endcase
  end
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
  import fpcsr_pkg::*;
#(
  parameter bit COMPAT = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                rd_sel,
  output logic [WORD_W-1:0]   rd_data,
  input  logic [NUM_FLAG-1:0] flag_pulse,
  output logic [1:0]          round_mode,
  output logic                mbz_err
);
  localparam int unsigned FLAG_MSB = FLAG_LSB + NUM_FLAG - 1;

  logic                ctrl_fire;
  logic                stat_fire;
  logic                mbz_set;
  logic                err_d;
  logic [WORD_W-1:0]   ctrl_q;
  logic [NUM_FLAG-1:0] flags_q;
  rnd_mode_e           mode;

  assign ctrl_fire = wr_en && (wr_sel == SEL_CTRL);
  assign stat_fire = wr_en && (wr_sel == SEL_STAT);
  assign mbz_set   = |wr_data[WORD_W-1:MBZ_LSB];

  fpcsr_ctrl_reg #(
    .DW(WORD_W), .KEEP_LO(CTL_KEEP), .GAP_HI(MBZ_LSB), .COMPAT(COMPAT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_fire(ctrl_fire), .wr_data(wr_data), .ctrl_q(ctrl_q)
  );

  fpcsr_flag_reg #(.NF(NUM_FLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_fire(stat_fire),
    .wr_flags(wr_data[FLAG_MSB:FLAG_LSB]), .pulse(flag_pulse), .flags_q(flags_q)
  );

  fpcsr_rnd_dec u_dec (.ctrl_lo(ctrl_q[1:0]), .mode(mode));
  assign round_mode = mode;

  always_comb begin
    err_d = (stat_fire && mbz_set) || (ctrl_fire && mbz_set && !COMPAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mbz_err <= 1'b0;
    else        mbz_err <= err_d;
  end

  always_comb begin
    if (rd_sel == SEL_STAT)
      rd_data = {{(WORD_W-FLAG_MSB-1){1'b0}}, flags_q, {FLAG_LSB{1'b0}}};
    else
      rd_data = ctrl_q;
  end
endmodule

// File: rtl/fpcsr_chk.sv
module fpcsr_chk #(
  parameter bit COMPAT = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [31:0] wr_data,
  input logic [4:0]  flag_pulse,
  input logic [4:0]  flags_q,
  input logic [31:0] ctrl_q,
  input logic [1:0]  round_mode,
  input logic        mbz_err
);
  p_rnd_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (round_mode == $past(wr_data[1:0])));

  p_ctrl_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!COMPAT) |-> (ctrl_q[31:7] == '0));

  p_ctrl_gap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[11:7] == '0);

  p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mbz_err |-> ($past(wr_en) && ($past(wr_data[31:12]) != '0)));

  p_stat_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (flags_q == $past(wr_data[11:7])));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> (flags_q == ($past(flags_q) | $past(flag_pulse))));
endmodule

bind fpcsr_top fpcsr_chk #(.COMPAT(COMPAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .flag_pulse(flag_pulse), .flags_q(flags_q), .ctrl_q(ctrl_q),
  .round_mode(round_mode), .mbz_err(mbz_err)
);

// File: tb/tb_fpcsr_top.sv
module tb_fpcsr_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_sel, rd_sel;
  logic [31:0] wr_data;
  logic [4:0]  flag_pulse;
  logic [31:0] rd_data, rd_data_c;
  logic [1:0]  round_mode, round_mode_c;
  logic        mbz_err, mbz_err_c;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpcsr_top #(.COMPAT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .flag_pulse(flag_pulse),
    .round_mode(round_mode), .mbz_err(mbz_err));

  fpcsr_top #(.COMPAT(1'b1)) dut_c (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data_c), .flag_pulse(flag_pulse),
    .round_mode(round_mode_c), .mbz_err(mbz_err_c));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Write at a negedge; results visible at the following negedge.
  task automatic do_write(logic sel, logic [31:0] d, logic [4:0] p);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; flag_pulse = p;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; flag_pulse = '0;
  endtask

  task automatic do_pulse(logic [4:0] p);
    flag_pulse = p;
    @(negedge clk);
    flag_pulse = '0;
  endtask

  task automatic t_reset;
    rd_sel = 1'b0; #1;
    check("R9 ctrl after reset", rd_data, 32'h0);
    check("R9 round mode after reset", {30'd0, round_mode}, 32'd0);
    check("R9 err after reset", {31'd0, mbz_err}, 32'd0);
    rd_sel = 1'b1; #1;
    check("R9 status after reset", rd_data, 32'h0);
  endtask

  task automatic t_round_modes;
    rd_sel = 1'b0;
    for (int m = 0; m < 4; m++) begin
      do_write(1'b0, 32'h0000_0000 | m, 5'd0);
      check("R1 round mode", {30'd0, round_mode}, m);
      check("R10 ctrl readback", rd_data, m);
    end
  endtask

  task automatic t_ctrl_mask;
    rd_sel = 1'b0;
    do_write(1'b0, 32'h0000_0F7E, 5'd0);
    check("R2 std keeps 6:0", rd_data, 32'h0000_007E);
    check("R3 compat drops 11:7", rd_data_c, 32'h0000_007E);
    check("R2 no err legal write", {31'd0, mbz_err}, 32'd0);
    do_write(1'b0, 32'hFFFF_FFFF, 5'd0);
    check("R4 std ctrl err pulse", {31'd0, mbz_err}, 32'd1);
    check("R3 compat ctrl no err", {31'd0, mbz_err_c}, 32'd0);
    check("R4 std legal bits kept", rd_data, 32'h0000_007F);
    check("R3 compat mask", rd_data_c, 32'hFFFF_F07F);
    check("R1 round mode 3", {30'd0, round_mode}, 32'd3);
    @(negedge clk);
    check("R4 err one cycle only", {31'd0, mbz_err}, 32'd0);
  endtask

  task automatic t_stat_write;
    rd_sel = 1'b1;
    do_write(1'b1, 32'hFFFF_FFFF, 5'd0);
    check("R5 status keeps 11:7", rd_data, 32'h0000_0F80);
    check("R4 std status err", {31'd0, mbz_err}, 32'd1);
    check("R4 compat status err", {31'd0, mbz_err_c}, 32'd1);
    do_write(1'b1, 32'h0000_0280, 5'd0);
    check("R6 status replaced", rd_data, 32'h0000_0280);
    check("R4 err cleared", {31'd0, mbz_err}, 32'd0);
    rd_sel = 1'b0; #1;
    check("R10 ctrl unchanged by status write", rd_data, 32'h0000_007F);
  endtask

  task automatic t_sticky;
    rd_sel = 1'b1;
    do_write(1'b1, 32'h0, 5'd0);
    do_pulse(5'b00001);
    check("R7 inexact bit 7", rd_data, 32'h0000_0080);
    do_pulse(5'b01000);
    check("R7 divzero bit 10 sticky", rd_data, 32'h0000_0480);
    @(negedge clk);
    check("R7 holds without pulse", rd_data, 32'h0000_0480);
    do_pulse(5'b10000);
    check("R5 invalid bit 11", rd_data, 32'h0000_0C80);
    do_write(1'b0, 32'h1, 5'b00010);
    check("R7 pulse during ctrl write", rd_data, 32'h0000_0D80);
  endtask

  task automatic t_collide;
    rd_sel = 1'b1;
    do_write(1'b1, 32'h0000_0100, 5'b10101);
    check("R8 write wins over pulses", rd_data, 32'h0000_0100);
    do_pulse(5'b00100);
    check("R8 accumulate after write", rd_data, 32'h0000_0300);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    rd_sel = 1'b0; flag_pulse = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_round_modes;
    t_ctrl_mask;
    t_stat_write;
    t_sticky;
    t_collide;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule